// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous NRZ characters on a serial line that idles high. It is clocked by the system clock and advances its bit timing only on a 16x sample-clock enable pulse. A falling line level starts a candidate character. That candidate is confirmed or rejected halfway into the start bit. Each later bit is sampled once near its centre. The assembled character goes into a one-entry holding register, together with its parity and framing status.

Software-facing logic reads the holding register with a one-cycle read strobe. The configuration inputs choose the word length, the parity behaviour and the stop-bit select. They are captured when a start bit is detected, so a change takes effect from the next character. A receiver-enable input gates new start bits only and never cuts a character short. After a framing error the receiver waits for a high (mark) level before it looks for a new start bit. This way a line held in break yields a single character and not a stream of them.

Top module: `async_rx`

## Requirements
- R1: Data bits arrive least significant first. The first data bit lands in `rdata[0]`, and the bits above the word length read as 0.
- R2: `cfg_wlen` selects 5, 6, 7 or 8 data bits (encodings 0, 1, 2, 3). The parity bit, when present, is checked and never stored in `rdata`.
- R3: `cfg_par_mode` encodes 0 = odd, 1 = even, 2 = mark, 3 = space. Odd and even are checked when `cfg_par_en` is 1. Mark and space never raise `perr`, whatever the received parity bit.
- R4: A low level that is high again at the start-bit midpoint (8 sample ticks after detection) is a false start. No character is received from it.
- R5: When a character is transferred, `full` is set, and `perr` and `ferr` take that character's parity and missing-stop status.
- R6: If a character completes while `full` is 1 and no read happens, the character is discarded, `oerr` is set and `rdata` keeps the older character.
- R7: With `cfg_stop_sel` = 0 there is one stop bit. With it set, 5-bit words without parity use 1.5 stop bits, 8-bit words with parity use one, and every other format uses two.
- R8: `full` rises at the sample tick 9/16 into the (last) stop bit. In the 1.5-stop format it rises 12 ticks after the first stop sample, halfway through the trailing half bit.
- R9: After a character with a framing error, no new start bit is accepted until the line has been sampled high.
- R10: A read strobe clears `full`, `perr`, `ferr` and `oerr`.
- R11: With `rx_en` low, no new character starts. A character already in progress still completes and is delivered.
- R12: After reset, `full`, `perr`, `ferr`, `oerr` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | 16x bit-rate enable pulse, one clock wide |
| rxd | input | 1 | Serial line, idle high, asynchronous to clk |
| rx_en | input | 1 | Allows new start bits when 1 |
| cfg_wlen | input | 2 | Word length: 0..3 = 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present and handled |
| cfg_par_mode | input | 2 | 0 odd, 1 even, 2 mark, 3 space |
| cfg_stop_sel | input | 1 | Extended stop-bit select |
| rd | input | 1 | Holding-register read strobe |
| rdata | output | 8 | Holding-register character |
| full | output | 1 | Holding register holds an unread character |
| perr | output | 1 | Parity error on the held character |
| ferr | output | 1 | Framing error on the held character |
| oerr | output | 1 | A character was lost to overrun |

## Verification
The assertions cover the handoff between the framing engine and the holding register on every cycle. A delivered character must raise `full`. Error flags never stand without `full`. A read clears every flag. An overrun leaves `rdata` untouched. A framing error keeps the receiver busy. An idle receiver stays idle while disabled. The bit timing needs whole serial frames, and only the bench scenarios exercise it: the exact tick at which `full` rises in each stop format, data alignment for every word length, parity handling per mode, false-start rejection and the mark wait after a break.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int MAX_WORD = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_MARKWAIT
    } rx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_e;

    localparam logic [1:0] PAR_ODD   = 2'd0;
    localparam logic [1:0] PAR_EVEN  = 2'd1;

    typedef struct packed {
        logic [MAX_WORD-1:0] data;
        logic                perr;
        logic                ferr;
    } rx_char_t;

    function automatic stop_e stop_rule(input logic [1:0] wlen,
                                        input logic par_en,
                                        input logic stop_sel);
        if (!stop_sel)
            return STOP_ONE;
        else if (wlen == 2'd0 && !par_en)
            return STOP_ONE_HALF;
        else if (wlen == 2'd3 && par_en)
            return STOP_ONE;
        else
            return STOP_TWO;
    endfunction

    // shift register fills from the top; move the word down to bit 0
    function automatic logic [MAX_WORD-1:0] align_word(input logic [MAX_WORD-1:0] sr,
                                                       input logic [1:0] wlen);
        return sr >> (2'd3 - wlen);
    endfunction

    function automatic logic parity_bad(input logic [1:0] mode,
                                        input logic [MAX_WORD-1:0] word,
                                        input logic pbit);
        logic total;
        total = (^word) ^ pbit;
        if (mode == PAR_ODD)
            return !total;
        else if (mode == PAR_EVEN)
            return total;
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '1;
        else
            q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
    import async_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxs,
    input  logic       rx_en,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_stop_sel,
    output logic       done,
    output rx_char_t   done_char,
    output logic       busy
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'((OSR * 3) / 4 - 1);

    rx_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [2:0]           bit_cnt;
    logic [MAX_WORD-1:0]  sr;
    logic                 par_q;
    logic                 fe_q;
    logic                 stop_idx;
    logic [1:0]           wlen_q;
    logic                 pen_q;
    logic [1:0]           pmode_q;
    stop_e                skind_q;

    logic [MAX_WORD-1:0]  word_al;
    logic                 par_err;
    logic [CNT_W-1:0]     stop_lim;
    logic                 stop_last;
    logic                 fe_next;
    logic [2:0]           last_bit;

    assign word_al   = align_word(sr, wlen_q);
    assign par_err   = pen_q && parity_bad(pmode_q, word_al, par_q);
    assign stop_lim  = (stop_idx && skind_q == STOP_ONE_HALF) ? HALF_LAST : BIT_LAST;
    assign stop_last = (skind_q == STOP_ONE) || stop_idx;
    assign fe_next   = fe_q || !rxs;
    assign last_bit  = 3'(wlen_q) + 3'd4;
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bit_cnt   <= '0;
            sr        <= '0;
            par_q     <= 1'b0;
            fe_q      <= 1'b0;
            stop_idx  <= 1'b0;
            wlen_q    <= '0;
            pen_q     <= 1'b0;
            pmode_q   <= '0;
            skind_q   <= STOP_ONE;
            done      <= 1'b0;
            done_char <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (rx_en && !rxs) begin
                            state   <= ST_START;
                            cnt     <= '0;
                            wlen_q  <= cfg_wlen;
                            pen_q   <= cfg_par_en;
                            pmode_q <= cfg_par_mode;
                            skind_q <= stop_rule(cfg_wlen, cfg_par_en, cfg_stop_sel);
                        end
                    end
                    ST_START: begin
                        if (cnt == MID_LAST) begin
                            cnt     <= '0;
                            bit_cnt <= '0;
                            state   <= rxs ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == BIT_LAST) begin
                            cnt     <= '0;
                            sr      <= {rxs, sr[MAX_WORD-1:1]};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == last_bit) begin
                                state    <= pen_q ? ST_PAR : ST_STOP;
                                stop_idx <= 1'b0;
                                fe_q     <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == BIT_LAST) begin
                            cnt   <= '0;
                            par_q <= rxs;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == stop_lim) begin
                            cnt <= '0;
                            if (stop_last) begin
                                done           <= 1'b1;
                                done_char.data <= word_al;
                                done_char.perr <= par_err;
                                done_char.ferr <= fe_next;
                                state          <= fe_next ? ST_MARKWAIT : ST_IDLE;
                            end else begin
                                stop_idx <= 1'b1;
                                fe_q     <= fe_next;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_MARKWAIT: begin
                        if (rxs)
                            state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold
    import async_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  rx_char_t            done_char,
    input  logic                rd,
    output logic [MAX_WORD-1:0] rdata,
    output logic                full,
    output logic                perr,
    output logic                ferr,
    output logic                oerr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            full  <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            oerr  <= 1'b0;
        end else begin
            if (rd) begin
                full <= 1'b0;
                perr <= 1'b0;
                ferr <= 1'b0;
                oerr <= 1'b0;
            end
            if (done) begin
                if (full && !rd) begin
                    oerr <= 1'b1;
                end else begin
                    rdata <= done_char.data;
                    full  <= 1'b1;
                    perr  <= done_char.perr;
                    ferr  <= done_char.ferr;
                end
            end
        end
    end
endmodule

// File: rtl/async_rx.sv
module async_rx
    import async_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_stop_sel,
    input  logic       rd,
    output logic [7:0] rdata,
    output logic       full,
    output logic       perr,
    output logic       ferr,
    output logic       oerr
);
    logic     rx_line;
    logic     rx_done;
    rx_char_t rx_char;
    logic     rx_busy;
    logic     char_ferr;

    assign char_ferr = rx_char.ferr;

    async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_line)
    );

    async_rx_frame #(.OSR(OSR)) u_frame (
        .clk          (clk),
        .rst          (rst),
        .tick         (sample_tick),
        .rxs          (rx_line),
        .rx_en        (rx_en),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_mode (cfg_par_mode),
        .cfg_stop_sel (cfg_stop_sel),
        .done         (rx_done),
        .done_char    (rx_char),
        .busy         (rx_busy)
    );

    async_rx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .done      (rx_done),
        .done_char (rx_char),
        .rd        (rd),
        .rdata     (rdata),
        .full      (full),
        .perr      (perr),
        .ferr      (ferr),
        .oerr      (oerr)
    );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic       done_ferr,
    input logic       busy,
    input logic       rx_en,
    input logic       rd,
    input logic [7:0] rdata,
    input logic       full,
    input logic       perr,
    input logic       ferr,
    input logic       oerr
);
    p_done_sets_full_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> full);

    p_flags_need_full_r5: assert property (@(posedge clk) disable iff (rst)
        (perr || ferr || oerr) |-> full);

    p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (done && full && !rd) |=> (oerr && rdata == $past(rdata)));

    p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (rd && !done) |=> !(full || perr || ferr || oerr));

    p_ferr_waits_mark_r9: assert property (@(posedge clk) disable iff (rst)
        (done && done_ferr) |=> busy);

    p_disabled_stays_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rx_en) |=> !busy);
endmodule

bind async_rx async_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (rx_done),
    .done_ferr (char_ferr),
    .busy      (rx_busy),
    .rx_en     (rx_en),
    .rd        (rd),
    .rdata     (rdata),
    .full      (full),
    .perr      (perr),
    .ferr      (ferr),
    .oerr      (oerr)
);

// File: tb/async_rx_tb.sv
`timescale 1ns/1ps
module async_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cfg_stop_sel = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       full, perr, ferr, oerr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    async_rx u_dut (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .rxd(rxd),
        .rx_en(rx_en), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
        .cfg_par_mode(cfg_par_mode), .cfg_stop_sel(cfg_stop_sel), .rd(rd),
        .rdata(rdata), .full(full), .perr(perr), .ferr(ferr), .oerr(oerr)
    );

    typedef struct packed {
        logic [1:0] wl;
        logic       pen;
        logic [1:0] pm;
        logic       s2;
        logic [7:0] din;
        logic       flip;
        logic       badstop;
        logic [7:0] xd;
        logic       xpe;
        logic       xfe;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
        '{2'd0, 1'b0, 2'd0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
        '{2'd1, 1'b1, 2'd0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
        '{2'd2, 1'b1, 2'd1, 1'b0, 8'h55, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0},
        '{2'd3, 1'b1, 2'd2, 1'b0, 8'h81, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0},
        '{2'd3, 1'b1, 2'd3, 1'b0, 8'hC3, 1'b1, 1'b0, 8'hC3, 1'b0, 1'b0},
        '{2'd3, 1'b0, 2'd0, 1'b0, 8'h5A, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1},
        '{2'd0, 1'b0, 2'd0, 1'b1, 8'h0A, 1'b0, 1'b0, 8'h0A, 1'b0, 1'b0},
        '{2'd3, 1'b1, 2'd0, 1'b1, 8'h96, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0},
        '{2'd2, 1'b0, 2'd0, 1'b1, 8'h7E, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0},
        '{2'd3, 1'b1, 2'd1, 1'b0, 8'h0F, 1'b1, 1'b0, 8'h0F, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one 16x tick; line value set before the call is seen at this tick,
    // and a register written at the tick is visible on return
    task automatic step();
        repeat (2) @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic line_steps(input logic v, input int n);
        rxd = v;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_read();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    // ticks from the start of the stop region to the delivery tick (R7, R8)
    function automatic int done_off(input logic [1:0] wl, input logic pen, input logic s2);
        if (!s2) return 9;
        if (wl == 2'd0 && !pen) return 21;
        if (wl == 2'd3 && pen) return 9;
        return 25;
    endfunction

    task automatic run_frame(input logic [7:0] d, input int nw, input bit pen,
                             input bit pv, input bit sv, input bit chk,
                             input int done_at, input int dis_at);
        int nbits;
        int total;
        nbits = 1 + nw + (pen ? 1 : 0);
        total = nbits * 16 + 40;
        for (int k = 1; k <= total; k++) begin
            int idx;
            idx = (k - 1) / 16;
            if (idx == 0) rxd = 1'b0;
            else if (idx <= nw) rxd = d[idx-1];
            else if (pen && idx == nw + 1) rxd = pv;
            else rxd = sv;
            if (k == dis_at) rx_en = 1'b0;
            if (chk && k == done_at) check("R8 full before delivery tick", full, 0);
            step();
            if (chk && k == done_at) check("R8 full at delivery tick", full, 1);
        end
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic pen, input logic [1:0] pm, input logic s2);
        cfg_wlen = wl; cfg_par_en = pen; cfg_par_mode = pm; cfg_stop_sel = s2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 full", full, 0);
        check("R12 perr", perr, 0);
        check("R12 ferr", ferr, 0);
        check("R12 oerr", oerr, 0);
        check("R12 rdata", rdata, 0);
        line_steps(1'b1, 4);

        // table walk: R1 R2 R3 R5 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int nw;
            logic [7:0] dm;
            logic pbit;
            v = VECS[i];
            nw = 5 + int'(v.wl);
            dm = v.din & ((8'd1 << nw) - 8'd1);
            case (v.pm)
                2'd0: pbit = ~(^dm);
                2'd1: pbit = ^dm;
                2'd2: pbit = 1'b1;
                default: pbit = 1'b0;
            endcase
            pbit = pbit ^ v.flip;
            set_cfg(v.wl, v.pen, v.pm, v.s2);
            run_frame(v.din, nw, v.pen, pbit, !v.badstop, 1'b1,
                      (1 + nw + (v.pen ? 1 : 0)) * 16 + done_off(v.wl, v.pen, v.s2), 0);
            line_steps(1'b1, 6);
            check("R5 full after frame", full, 1);
            check("R1 R2 data aligned, parity stripped", rdata, v.xd);
            check("R3 parity flag", perr, v.xpe);
            check("R5 framing flag", ferr, v.xfe);
            do_read();
            check("R10 read clears full", full, 0);
            check("R10 read clears perr/ferr", {perr, ferr, oerr}, 0);
        end

        // R4 false start
        set_cfg(2'd3, 1'b0, 2'd0, 1'b0);
        line_steps(1'b0, 5);
        line_steps(1'b1, 60);
        check("R4 false start ignored", full, 0);
        run_frame(8'h5C, 8, 0, 0, 1, 0, 0, 0);
        line_steps(1'b1, 4);
        check("R4 next frame received", rdata, 8'h5C);
        do_read();

        // R6 overrun
        run_frame(8'hA1, 8, 0, 0, 1, 0, 0, 0);
        line_steps(1'b1, 4);
        run_frame(8'hB2, 8, 0, 0, 1, 0, 0, 0);
        line_steps(1'b1, 4);
        check("R6 overrun flag", oerr, 1);
        check("R6 older char kept", rdata, 8'hA1);
        check("R6 full stays", full, 1);
        do_read();
        check("R10 read clears overrun", {full, oerr}, 0);
        run_frame(8'hC3, 8, 0, 0, 1, 0, 0, 0);
        line_steps(1'b1, 4);
        check("R6 receive after overrun", rdata, 8'hC3);
        check("R6 no overrun", oerr, 0);
        do_read();

        // R9 break then mark wait
        run_frame(8'h00, 8, 0, 0, 0, 0, 0, 0);
        check("R9 break char framing", ferr, 1);
        check("R9 break char data", rdata, 8'h00);
        do_read();
        line_steps(1'b0, 250);
        check("R9 no char while line held low", full, 0);
        line_steps(1'b1, 20);
        run_frame(8'h33, 8, 0, 0, 1, 0, 0, 0);
        line_steps(1'b1, 4);
        check("R9 resumes after mark", rdata, 8'h33);
        check("R9 resumes full", full, 1);
        do_read();

        // R11 receiver disable
        rx_en = 1'b0;
        run_frame(8'h77, 8, 0, 0, 1, 0, 0, 0);
        line_steps(1'b1, 4);
        check("R11 disabled, nothing received", full, 0);
        rx_en = 1'b1;
        line_steps(1'b1, 4);
        run_frame(8'h6D, 8, 0, 0, 1, 0, 0, 40);
        line_steps(1'b1, 4);
        check("R11 in-progress char completes", full, 1);
        check("R11 in-progress char data", rdata, 8'h6D);
        do_read();
        rx_en = 1'b1;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule